// File: doc/BRIEF.md
# Buck Regulator Soft-Start and Fault Sequencer

This block is the digital control core of a step-down regulator. It decides when the power stage may switch. It produces a digital reference code that ramps the feedback target up during start-up. It drives a power-good level and reacts to window-comparator and temperature flags by latching a fault and commanding a safe state for the switches. All analog sensing happens outside the block; the block sees only flags and a one-cycle pulse per switching period.

A start needs three things: the enable pin high, both supply-lockout flags reporting good supplies, and no over-temperature condition. At the start the block captures the selections, with a one-cycle strobe for the frequency selector outside the block, and holds the voltage selection as its target code. The reference then climbs one 25 mV code every fixed number of switching ticks until it reaches the target. Undervoltage is ignored during a start-up blanking window. After that window a persistent undervoltage must outlast a tick timer before it latches. An overvoltage latches at once and clamps the output through the low-side switch. Every fault stays latched until the enable pin goes low or a power-on reset arrives.

Top module: `buck_seq`

## Requirements
- R1: After reset every output is 0. `conv_en` goes high only one clock after a cycle in which `en_i`, `bias_ok` and `vin_ok` are all high with the sequencer active; a start from idle also needs `ot_flag` low.
- R2: A start raises `sel_latch` for exactly one clock and loads `tgt_code` from `vsel` as the selected millivolts divided by 25 (0→30, 1→44, 2→60, 3→72). The value holds until the next start, whatever `vsel` does.
- R3: `ref_code` is 0 at a start and rises by 1 after every STEP_CYCLES qualifying ticks (`sw_tick` with both supplies good). It stops at `tgt_code`, and the sequencer then enters regulation.
- R4: `pgood` is low when idle, during soft-start, in a fault and during a supply pause. In regulation it is high one clock after a cycle with both `ov_flag` and `uv_flag` low, and low one clock after either is high.
- R5: `uv_flag` has no effect until BLANK_CYCLES qualifying ticks have passed since the start.
- R6: Once blanking is over, if `uv_flag` stays high for UV_CYCLES qualifying ticks, a fault latches: `conv_en` and `pgood` go low and `zc_stop` goes high.
- R7: `ov_flag` high while active latches a fault on the next clock: `lowside_on` high, `conv_en` and `pgood` low.
- R8: `ot_flag` high while active latches a fault in which `conv_en`, `lowside_on` and `zc_stop` are all low.
- R9: A latched fault survives its flag going away. Only `en_i` low or a `por` pulse clears it, and either one returns `ref_code` to 0.
- R10: With either supply flag low, `conv_en` and `pgood` are low, ticks are not counted, and operation resumes from the same point when the supplies recover.
- R11: If `uv_flag` drops before the timer expires, the timer restarts from zero and no fault latches.
- R12: After a thermal fault a restart needs `en_i` to go low and then high, and it begins only once `ot_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por | input | 1 | Power-on reset pulse, clears state and fault latch |
| en_i | input | 1 | Regulator enable |
| bias_ok | input | 1 | Bias supply above its lockout threshold |
| vin_ok | input | 1 | Input supply above its lockout threshold |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| vsel | input | 2 | Output voltage selection |
| ov_flag | input | 1 | Output above the upper window limit |
| uv_flag | input | 1 | Output below the lower window limit |
| ot_flag | input | 1 | Over-temperature indication |
| ref_code | output | REF_W | Soft-start reference, 25 mV per code |
| tgt_code | output | REF_W | Captured target code |
| pgood | output | 1 | Power-good level |
| conv_en | output | 1 | Power stage switching enable |
| lowside_on | output | 1 | Force low-side switch fully on |
| zc_stop | output | 1 | Shut down after the next zero crossing |
| sel_latch | output | 1 | Strobe that captures the selections |

## Verification
The bench puts an undervoltage on the output from the start and holds it longer than the fault timer while blanking is still running; a design that arms the timer too early would latch a false fault in the middle of the ramp. A short undervoltage burst after blanking checks that the timer restarts, since a timer that only paused would trip on a later burst. The bench also drops a supply in regulation to catch a design that keeps counting or keeps power-good high. It removes fault flags to catch latches that clear by themselves, and it keeps the temperature flag high across an enable toggle to catch a restart into a hot part.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SOFT = 2'd1,
    ST_RUN  = 2'd2,
    ST_FLT  = 2'd3
  } seq_st_t;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_UV   = 2'd1,
    FK_OV   = 2'd2,
    FK_OT   = 2'd3
  } flt_kind_t;

  // reference resolution in millivolts per code
  localparam int STEP_MV = 25;

  function automatic int sel_mv(input logic [1:0] s);
    case (s)
      2'd0:    return 750;
      2'd1:    return 1100;
      2'd2:    return 1500;
      default: return 1800;
    endcase
  endfunction

endpackage

// File: rtl/buck_seq_cnt.sv
// Tick counter that wraps at LIMIT and flags the tick that completes a period.
module buck_seq_cnt #(
  parameter int LIMIT = 61
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit = adv && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/buck_seq_ramp.sv
// Holds the captured target and steps the soft-start reference toward it.
module buck_seq_ramp
  import buck_seq_pkg::*;
#(
  parameter int REF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic             step,
  input  logic [1:0]       vsel,
  output logic [REF_W-1:0] ref_q,
  output logic [REF_W-1:0] tgt_q,
  output logic             reach
);
  logic [REF_W-1:0] sel_code;

  assign sel_code = REF_W'(sel_mv(vsel) / STEP_MV);
  assign reach    = step && ((ref_q + 1'b1) == tgt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      tgt_q <= '0;
    end else begin
      if (clear || load) begin
        ref_q <= '0;
      end else if (step && (ref_q != tgt_q)) begin
        ref_q <= ref_q + 1'b1;
      end
      if (load) begin
        tgt_q <= sel_code;
      end
    end
  end
endmodule

// File: rtl/buck_seq.sv
module buck_seq
  import buck_seq_pkg::*;
#(
  parameter int REF_W        = 8,
  parameter int STEP_CYCLES  = 61,
  parameter int BLANK_CYCLES = 3055,
  parameter int UV_CYCLES    = 1600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             en_i,
  input  logic             bias_ok,
  input  logic             vin_ok,
  input  logic             sw_tick,
  input  logic [1:0]       vsel,
  input  logic             ov_flag,
  input  logic             uv_flag,
  input  logic             ot_flag,
  output logic [REF_W-1:0] ref_code,
  output logic [REF_W-1:0] tgt_code,
  output logic             pgood,
  output logic             conv_en,
  output logic             lowside_on,
  output logic             zc_stop,
  output logic             sel_latch
);
  seq_st_t   st_q, st_d;
  flt_kind_t kind_q, kind_d;

  logic srst, sup_ok, run_tick, active, start;
  logic step_hit, blank_hit, uv_hit, reach, armed_q;
  logic nxt_active, nxt_idle;

  assign srst       = rst || por;
  assign sup_ok     = bias_ok && vin_ok;
  assign run_tick   = sw_tick && sup_ok;
  assign active     = (st_q == ST_SOFT) || (st_q == ST_RUN);
  assign nxt_active = (st_d == ST_SOFT) || (st_d == ST_RUN);
  assign nxt_idle   = (st_d == ST_OFF) || (st_d == ST_FLT);
  assign start      = (st_q == ST_OFF) && (st_d == ST_SOFT);

  // reference step divider, soft-start only
  buck_seq_cnt #(.LIMIT(STEP_CYCLES)) u_step_cnt (
    .clk (clk),
    .rst (srst),
    .clr (st_q != ST_SOFT),
    .adv (run_tick),
    .hit (step_hit)
  );

  // start-up blanking before undervoltage is watched
  buck_seq_cnt #(.LIMIT(BLANK_CYCLES)) u_blank_cnt (
    .clk (clk),
    .rst (srst),
    .clr (!active),
    .adv (run_tick),
    .hit (blank_hit)
  );

  // undervoltage qualification timer, restarts when the flag drops
  buck_seq_cnt #(.LIMIT(UV_CYCLES)) u_uv_cnt (
    .clk (clk),
    .rst (srst),
    .clr (!(active && armed_q && uv_flag)),
    .adv (run_tick),
    .hit (uv_hit)
  );

  buck_seq_ramp #(.REF_W(REF_W)) u_ramp (
    .clk   (clk),
    .rst   (srst),
    .load  (start),
    .clear (nxt_idle),
    .step  (step_hit),
    .vsel  (vsel),
    .ref_q (ref_code),
    .tgt_q (tgt_code),
    .reach (reach)
  );

  always_ff @(posedge clk) begin
    if (srst || !active) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_q || blank_hit;
    end
  end

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    if (!en_i) begin
      st_d   = ST_OFF;
      kind_d = FK_NONE;
    end else begin
      case (st_q)
        ST_OFF: begin
          if (sup_ok && !ot_flag) st_d = ST_SOFT;
        end
        ST_SOFT, ST_RUN: begin
          if (ot_flag) begin
            st_d   = ST_FLT;
            kind_d = FK_OT;
          end else if (ov_flag) begin
            st_d   = ST_FLT;
            kind_d = FK_OV;
          end else if (uv_hit) begin
            st_d   = ST_FLT;
            kind_d = FK_UV;
          end else if ((st_q == ST_SOFT) && reach) begin
            st_d = ST_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      st_q       <= ST_OFF;
      kind_q     <= FK_NONE;
      conv_en    <= 1'b0;
      pgood      <= 1'b0;
      lowside_on <= 1'b0;
      zc_stop    <= 1'b0;
      sel_latch  <= 1'b0;
    end else begin
      st_q       <= st_d;
      kind_q     <= kind_d;
      conv_en    <= nxt_active && sup_ok;
      pgood      <= (st_d == ST_RUN) && sup_ok && !ov_flag && !uv_flag;
      lowside_on <= (st_d == ST_FLT) && (kind_d == FK_OV);
      zc_stop    <= (st_d == ST_FLT) && (kind_d == FK_UV);
      sel_latch  <= start;
    end
  end
endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk #(
  parameter int REF_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             bias_ok,
  input logic             vin_ok,
  input logic             ov_flag,
  input logic             uv_flag,
  input logic [REF_W-1:0] ref_code,
  input logic [REF_W-1:0] tgt_code,
  input logic             pgood,
  input logic             conv_en,
  input logic             lowside_on,
  input logic             zc_stop,
  input logic             sel_latch
);
  a_r1_enable_source: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> $past(en_i && bias_ok && vin_ok));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    sel_latch |=> !sel_latch);

  a_r3_ref_bounded: assert property (@(posedge clk) disable iff (rst)
    ref_code <= tgt_code);

  a_r3_ref_unit_step: assert property (@(posedge clk) disable iff (rst)
    ((ref_code != $past(ref_code)) && (ref_code != '0))
      |-> (ref_code == $past(ref_code) + 1'b1));

  a_r4_pg_window: assert property (@(posedge clk) disable iff (rst)
    pgood |-> $past(!ov_flag && !uv_flag));

  a_r4_pg_needs_switching: assert property (@(posedge clk) disable iff (rst)
    pgood |-> conv_en);

  a_r7_drive_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({conv_en, lowside_on, zc_stop}));
endmodule

bind buck_seq buck_seq_chk #(.REF_W(REF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .bias_ok    (bias_ok),
  .vin_ok     (vin_ok),
  .ov_flag    (ov_flag),
  .uv_flag    (uv_flag),
  .ref_code   (ref_code),
  .tgt_code   (tgt_code),
  .pgood      (pgood),
  .conv_en    (conv_en),
  .lowside_on (lowside_on),
  .zc_stop    (zc_stop),
  .sel_latch  (sel_latch)
);

// File: tb/buck_seq_bench.sv
module buck_seq_bench;
  localparam int RW    = 8;
  localparam int STEP  = 4;
  localparam int BLANK = 150;
  localparam int UVC   = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, por = 1'b0, en_i = 1'b0, bias_ok = 1'b0, vin_ok = 1'b0;
  logic sw_tick = 1'b0, ov_flag = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
  logic [1:0] vsel = 2'd1;
  logic [RW-1:0] ref_code, tgt_code;
  logic pgood, conv_en, lowside_on, zc_stop, sel_latch;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  buck_seq #(.REF_W(RW), .STEP_CYCLES(STEP), .BLANK_CYCLES(BLANK), .UV_CYCLES(UVC)) u_buck_seq (
    .clk(clk), .rst(rst), .por(por), .en_i(en_i), .bias_ok(bias_ok), .vin_ok(vin_ok),
    .sw_tick(sw_tick), .vsel(vsel), .ov_flag(ov_flag), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .ref_code(ref_code), .tgt_code(tgt_code), .pgood(pgood), .conv_en(conv_en),
    .lowside_on(lowside_on), .zc_stop(zc_stop), .sel_latch(sel_latch)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code_of(input logic [1:0] s);
    case (s)
      2'd0: return 750 / 25;
      2'd1: return 1100 / 25;
      2'd2: return 1500 / 25;
      default: return 1800 / 25;
    endcase
  endfunction

  // switching tick every third clock, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    sw_tick = (cyc % 3 == 0);
  end

  // behavioural reference: 0 idle, 1 soft-start, 2 regulate, 3 fault
  int m_st = 0, m_kind = 0, m_ref = 0, m_tgt = 0, m_step = 0, m_blank = 0, m_uv = 0;
  bit m_conv = 0, m_pg = 0, m_ls = 0, m_zc = 0, m_stb = 0;

  always @(posedge clk) begin : model
    int nst, nk;
    bit sok, rt, act, armed, sth, uvh, reach, start;
    if (rst || por) begin
      m_st = 0; m_kind = 0; m_ref = 0; m_tgt = 0; m_step = 0; m_blank = 0; m_uv = 0;
      m_conv = 0; m_pg = 0; m_ls = 0; m_zc = 0; m_stb = 0;
    end else begin
      sok   = bias_ok && vin_ok;
      rt    = sw_tick && sok;
      act   = (m_st == 1) || (m_st == 2);
      armed = (m_blank >= BLANK);
      sth   = (m_st == 1) && rt && (m_step == STEP - 1);
      uvh   = act && armed && uv_flag && rt && (m_uv == UVC - 1);
      reach = sth && (m_ref + 1 == m_tgt);
      nst = m_st; nk = m_kind;
      if (!en_i) begin
        nst = 0; nk = 0;
      end else if (m_st == 0) begin
        if (sok && !ot_flag) nst = 1;
      end else if (act) begin
        if (ot_flag) begin nst = 3; nk = 3; end
        else if (ov_flag) begin nst = 3; nk = 2; end
        else if (uvh) begin nst = 3; nk = 1; end
        else if (m_st == 1 && reach) nst = 2;
      end
      start = (m_st == 0) && (nst == 1);
      if (m_st != 1) m_step = 0;
      else if (rt) m_step = (m_step == STEP - 1) ? 0 : m_step + 1;
      if (!act) m_blank = 0;
      else if (rt && m_blank < BLANK) m_blank++;
      if (!(act && armed && uv_flag)) m_uv = 0;
      else if (rt) m_uv = (m_uv == UVC - 1) ? 0 : m_uv + 1;
      if (nst == 0 || nst == 3 || start) m_ref = 0;
      else if (sth && m_ref != m_tgt) m_ref++;
      if (start) m_tgt = code_of(vsel);
      m_conv = (nst == 1 || nst == 2) && sok;
      m_pg   = (nst == 2) && sok && !ov_flag && !uv_flag;
      m_ls   = (nst == 3) && (nk == 2);
      m_zc   = (nst == 3) && (nk == 1);
      m_stb  = start;
      m_st = nst; m_kind = nk;
    end
  end

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 ref_code model", int'(ref_code), m_ref);
      chk("R2 tgt_code model", int'(tgt_code), m_tgt);
      chk("R4 pgood model", int'(pgood), int'(m_pg));
      chk("R1 conv_en model", int'(conv_en), int'(m_conv));
      chk("R7 lowside_on model", int'(lowside_on), int'(m_ls));
      chk("R6 zc_stop model", int'(zc_stop), int'(m_zc));
      chk("R2 sel_latch model", int'(sel_latch), int'(m_stb));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    step(3);
    rst = 1'b0;
    step(1);
    // R1: reset state
    chk("R1 reset conv_en", int'(conv_en), 0);
    chk("R1 reset pgood", int'(pgood), 0);
    chk("R1 reset ref_code", int'(ref_code), 0);

    // R1: input supply missing keeps switching off
    en_i = 1'b1; bias_ok = 1'b1;
    step(20);
    chk("R1 no start without vin_ok", int'(conv_en), 0);

    // R2: start captures selection 1 -> 44
    vin_ok = 1'b1;
    step(1);
    chk("R2 strobe at start", int'(sel_latch), 1);
    chk("R2 captured target", int'(tgt_code), 44);
    chk("R1 switching on", int'(conv_en), 1);
    chk("R4 pgood low in soft-start", int'(pgood), 0);
    step(1);
    chk("R2 strobe one clock", int'(sel_latch), 0);
    vsel = 2'd3;

    // R3: ramp completes, target held
    step(600);
    chk("R3 ref at target", int'(ref_code), 44);
    chk("R2 target held", int'(tgt_code), 44);
    chk("R4 pgood in regulation", int'(pgood), 1);

    // R11: short undervoltage after blanking
    uv_flag = 1'b1;
    step(1);
    chk("R4 pgood drops on uv", int'(pgood), 0);
    step(30);
    uv_flag = 1'b0;
    step(2);
    chk("R11 no fault after short uv", int'(zc_stop), 0);
    chk("R11 still switching", int'(conv_en), 1);
    chk("R4 pgood back", int'(pgood), 1);

    // R10: supply pause
    bias_ok = 1'b0;
    step(2);
    chk("R10 paused conv_en", int'(conv_en), 0);
    chk("R10 paused pgood", int'(pgood), 0);
    step(30);
    bias_ok = 1'b1;
    step(2);
    chk("R10 resumed conv_en", int'(conv_en), 1);
    chk("R10 ref kept", int'(ref_code), 44);

    // R6: sustained undervoltage
    uv_flag = 1'b1;
    step(70);
    chk("R6 uv fault zc_stop", int'(zc_stop), 1);
    chk("R6 uv fault conv_en", int'(conv_en), 0);
    uv_flag = 1'b0;
    step(5);
    chk("R9 uv fault holds", int'(zc_stop), 1);
    en_i = 1'b0;
    step(2);
    chk("R9 enable low clears", int'(zc_stop), 0);
    chk("R9 ref cleared", int'(ref_code), 0);

    // R5: undervoltage during blanking is ignored
    vsel = 2'd0; uv_flag = 1'b1; en_i = 1'b1;
    step(300);
    chk("R5 uv ignored in blanking", int'(conv_en), 1);
    chk("R5 no uv fault", int'(zc_stop), 0);
    uv_flag = 1'b0;
    step(100);
    chk("R3 ramp to 30", int'(ref_code), 30);
    chk("R2 target 30", int'(tgt_code), 30);

    // R7: overvoltage clamp
    step(200);
    ov_flag = 1'b1;
    step(1);
    chk("R7 lowside on", int'(lowside_on), 1);
    chk("R7 conv_en off", int'(conv_en), 0);
    chk("R7 pgood off", int'(pgood), 0);
    ov_flag = 1'b0;
    step(3);
    chk("R9 ov fault holds", int'(lowside_on), 1);
    por = 1'b1;
    step(1);
    chk("R9 por clears", int'(lowside_on), 0);
    por = 1'b0;
    step(2);
    chk("R9 restart after por", int'(conv_en), 1);

    // R8 / R12: thermal fault and restart rule
    ot_flag = 1'b1;
    step(1);
    chk("R8 ot conv_en", int'(conv_en), 0);
    chk("R8 ot lowside", int'(lowside_on), 0);
    chk("R8 ot zc", int'(zc_stop), 0);
    en_i = 1'b0;
    step(2);
    en_i = 1'b1;
    step(5);
    chk("R12 no restart while hot", int'(conv_en), 0);
    ot_flag = 1'b0;
    step(2);
    chk("R12 restart when cool", int'(conv_en), 1);
    step(10);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule